// File: doc/BRIEF.md
# Masked Share-Domain Boolean Gadget

This block evaluates Boolean operations on a single secret bit that never exists in plain form inside the logic. The bit is carried as a vector of `NSH = 2*T_PROBE + 1` shares whose XOR equals the secret. `T_PROBE` is the number of wires an attacker is assumed to probe at once. The gadget computes AND of two shared bits with fresh pairwise masks on the cross terms. It computes NOT by flipping a single share, and it can re-randomise the share vector it already holds while keeping the value it represents.

Mask bits come from an internal 32-bit Galois LFSR. The LFSR is loaded from a nonzero seed at reset and steps once for every accepted operation. Its state is XORed with an external entropy word, `ent_i`, to form the mask supply. A caller drives one operation per cycle with `in_valid_i`. The result shares sit in one output register and appear with `out_valid_o` one cycle later.

The pairwise mask supply needs `NSH*(NSH-1)/2` bits per cycle. That fits within the LFSR width for `T_PROBE` up to 3.

Top module: `masked_share_gadget`

## Requirements
- R1: While `rst` is high and after it falls, until the first accepted operation, `out_valid_o` is 0 and every bit of `c_sh_o` is 0.
- R2: `out_valid_o` is 1 in exactly the cycle after a cycle in which `in_valid_i` was 1, and 0 otherwise.
- R3: With `op_i = 2'b00` (AND), the XOR of all bits of `c_sh_o` equals (XOR of `a_sh_i`) AND (XOR of `b_sh_i`), for any `ent_i` and for both `T_PROBE = 1` and `T_PROBE = 2`.
- R4: With `op_i = 2'b01` (NOT of a), bit 0 of `c_sh_o` is the inverse of bit 0 of `a_sh_i`, and bits 1 to NSH-1 equal the matching bits of `a_sh_i`, so the recombined result is the inverse of the recombined `a_sh_i`.
- R5: With `op_i = 2'b10` (REFRESH), the recombined value of the held share vector is unchanged, whatever `a_sh_i` and `b_sh_i` carry.
- R6: In a cycle with `in_valid_i` low, the held `c_sh_o` does not change.
- R7: The LFSR steps on every accepted operation, so a run of REFRESH operations with `ent_i = 0` changes the share pattern while keeping its XOR.
- R8: With `op_i = 2'b11` (LOAD), `c_sh_o` takes `a_sh_i` bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | 00 AND, 01 NOT, 10 REFRESH, 11 LOAD |
| a_sh_i | input | NSH | Shares of operand a |
| b_sh_i | input | NSH | Shares of operand b |
| ent_i | input | LFSR_W | External entropy XORed into the mask supply |
| out_valid_o | output | 1 | Result valid, one cycle after the strobe |
| c_sh_o | output | NSH | Registered result shares |

## Verification
The bench drives AND under every recombined input pair and with random entropy words, at three and at five shares. A wrong mirrored-mask expression or a mistaken pair index would cancel the wrong cross term and flip the recombined result. NOT is checked share by share: a design that inverts every share, or the last one, gives the wrong value for an even share count or exposes the wrong share. Long REFRESH chains check that the stored value survives, that the pattern really moves, and that a stray operand does not leak in. Mid-run reset and idle cycles check that nothing is clocked into the result register without a strobe.

// File: rtl/mask_gadget_pkg.sv
package mask_gadget_pkg;

  typedef enum logic [1:0] {
    OP_AND     = 2'b00,
    OP_NOT     = 2'b01,
    OP_REFRESH = 2'b10,
    OP_LOAD    = 2'b11
  } share_op_e;

  // number of unordered share pairs for n shares
  function automatic int pair_total(input int n);
    return (n * (n - 1)) / 2;
  endfunction

  // linear slot of pair (i,j), i<j, in row-major upper-triangle order
  function automatic int pair_slot(input int i, input int j, input int n);
    return i * n - (i * (i + 1)) / 2 + (j - i - 1);
  endfunction

endpackage

// File: rtl/mg_lfsr.sv
module mg_lfsr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] TAPS = 32'h8020_0003,
  parameter logic [W-1:0] SEED = 32'hACE1_2468
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] state_o
);
  // an all-zero seed would lock the register, so substitute one
  localparam logic [W-1:0] SEED_EFF = (SEED == '0) ? {{(W-1){1'b0}}, 1'b1} : SEED;

  logic [W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEED_EFF;
    end else if (step) begin
      state_q <= {1'b0, state_q[W-1:1]} ^ (state_q[0] ? TAPS : '0);
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/mg_and_core.sv
module mg_and_core
  import mask_gadget_pkg::*;
#(
  parameter int NSH   = 3,
  parameter int NPAIR = (NSH * (NSH - 1)) / 2
) (
  input  logic [NSH-1:0]   a_i,
  input  logic [NSH-1:0]   b_i,
  input  logic [NPAIR-1:0] r_i,
  output logic [NSH-1:0]   c_o
);
  logic [NSH-1:0][NSH-1:0] zm;

  always_comb begin
    zm = '0;
    for (int i = 0; i < NSH; i++) begin
      for (int j = i + 1; j < NSH; j++) begin
        zm[i][j] = r_i[pair_slot(i, j, NSH)];
        // order of the two XORs is fixed: mask with first cross term first
        zm[j][i] = (zm[i][j] ^ (a_i[i] & b_i[j])) ^ (a_i[j] & b_i[i]);
      end
    end
    for (int i = 0; i < NSH; i++) begin
      c_o[i] = a_i[i] & b_i[i];
      for (int j = 0; j < NSH; j++) begin
        if (j != i) c_o[i] = c_o[i] ^ zm[i][j];
      end
    end
  end
endmodule

// File: rtl/mg_refresh.sv
module mg_refresh #(
  parameter int NSH = 3
) (
  input  logic [NSH-1:0] s_i,
  input  logic [NSH-2:0] r_i,
  output logic [NSH-1:0] s_o
);
  genvar g;
  generate
    for (g = 0; g < NSH - 1; g++) begin : g_mask
      assign s_o[g] = s_i[g] ^ r_i[g];
    end
  endgenerate
  // last share absorbs the combined mask so the XOR is preserved
  assign s_o[NSH-1] = s_i[NSH-1] ^ (^r_i);
endmodule

// File: rtl/masked_share_gadget.sv
module masked_share_gadget
  import mask_gadget_pkg::*;
#(
  parameter int                T_PROBE   = 1,
  parameter int                LFSR_W    = 32,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 32'h8020_0003,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 32'hACE1_2468,
  localparam int               NSH       = 2 * T_PROBE + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid_i,
  input  logic [1:0]        op_i,
  input  logic [NSH-1:0]    a_sh_i,
  input  logic [NSH-1:0]    b_sh_i,
  input  logic [LFSR_W-1:0] ent_i,
  output logic              out_valid_o,
  output logic [NSH-1:0]    c_sh_o
);
  localparam int NPAIR = pair_total(NSH);

  share_op_e         op_e;
  logic [LFSR_W-1:0] lfsr_state;
  logic [LFSR_W-1:0] mask_pool;
  logic [NSH-1:0]    and_sh;
  logic [NSH-1:0]    ref_sh;
  logic [NSH-1:0]    not_sh;
  logic [NSH-1:0]    nxt_sh;
  logic [NSH-1:0]    c_q;
  logic              vld_q;

  assign op_e = share_op_e'(op_i);

  mg_lfsr #(
    .W   (LFSR_W),
    .TAPS(LFSR_TAPS),
    .SEED(LFSR_SEED)
  ) u_lfsr (
    .clk    (clk),
    .rst    (rst),
    .step   (in_valid_i),
    .state_o(lfsr_state)
  );

  assign mask_pool = lfsr_state ^ ent_i;

  mg_and_core #(
    .NSH  (NSH),
    .NPAIR(NPAIR)
  ) u_and (
    .a_i(a_sh_i),
    .b_i(b_sh_i),
    .r_i(mask_pool[NPAIR-1:0]),
    .c_o(and_sh)
  );

  mg_refresh #(
    .NSH(NSH)
  ) u_refresh (
    .s_i(c_q),
    .r_i(mask_pool[NSH-2:0]),
    .s_o(ref_sh)
  );

  // inversion lands on share 0 only
  assign not_sh = a_sh_i ^ {{(NSH-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (op_e)
      OP_AND:     nxt_sh = and_sh;
      OP_NOT:     nxt_sh = not_sh;
      OP_REFRESH: nxt_sh = ref_sh;
      OP_LOAD:    nxt_sh = a_sh_i;
      default:    nxt_sh = c_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c_q   <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_valid_i;
      if (in_valid_i) c_q <= nxt_sh;
    end
  end

  assign c_sh_o      = c_q;
  assign out_valid_o = vld_q;
endmodule

// File: rtl/mg_checker.sv
module mg_checker #(
  parameter int NSH = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid_i,
  input logic [1:0]     op_i,
  input logic [NSH-1:0] a_sh_i,
  input logic [NSH-1:0] b_sh_i,
  input logic           out_valid_o,
  input logic [NSH-1:0] c_sh_o
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid_o && c_sh_o == '0));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid_i |=> out_valid_o);

  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid_i |=> !out_valid_o);

  assert_and_value_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && op_i == 2'b00) |=> ((^c_sh_o) == ((^$past(a_sh_i)) & (^$past(b_sh_i)))));

  assert_not_shares_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && op_i == 2'b01) |=>
      (c_sh_o[NSH-1:1] == $past(a_sh_i[NSH-1:1]) && c_sh_o[0] == !$past(a_sh_i[0])));

  assert_refresh_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && op_i == 2'b10) |=> ((^c_sh_o) == $past(^c_sh_o)));

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid_i |=> $stable(c_sh_o));

  assert_load_copy_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && op_i == 2'b11) |=> (c_sh_o == $past(a_sh_i)));
endmodule

bind masked_share_gadget mg_checker #(.NSH(NSH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid_i (in_valid_i),
  .op_i       (op_i),
  .a_sh_i     (a_sh_i),
  .b_sh_i     (b_sh_i),
  .out_valid_o(out_valid_o),
  .c_sh_o     (c_sh_o)
);

// File: tb/masked_share_gadget_tb.sv
module masked_share_gadget_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [2:0]  a1 = '0, b1 = '0;
  logic [4:0]  a2 = '0, b2 = '0;
  logic [31:0] ent = '0;
  logic        ov1, ov2;
  logic [2:0]  c1;
  logic [4:0]  c2;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  masked_share_gadget #(.T_PROBE(1)) u_dut (
    .clk(clk), .rst(rst), .in_valid_i(in_valid), .op_i(op),
    .a_sh_i(a1), .b_sh_i(b1), .ent_i(ent),
    .out_valid_o(ov1), .c_sh_o(c1)
  );

  masked_share_gadget #(.T_PROBE(2), .LFSR_SEED(32'h1357_9BDF)) u_dut_t2 (
    .clk(clk), .rst(rst), .in_valid_i(in_valid), .op_i(op),
    .a_sh_i(a2), .b_sh_i(b2), .ent_i(ent),
    .out_valid_o(ov2), .c_sh_o(c2)
  );

  // {op[1:0], a[2:0], b[2:0], expected recombined bit}
  localparam logic [8:0] VEC [8] = '{
    {2'b00, 3'b001, 3'b011, 1'b0},
    {2'b00, 3'b001, 3'b111, 1'b1},
    {2'b00, 3'b110, 3'b111, 1'b0},
    {2'b00, 3'b111, 3'b100, 1'b1},
    {2'b01, 3'b000, 3'b000, 1'b1},
    {2'b01, 3'b101, 3'b010, 1'b1},
    {2'b01, 3'b111, 3'b000, 1'b0},
    {2'b00, 3'b010, 3'b010, 1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // drive one operation at a falling edge; returns at the next falling edge
  task automatic run_op(input logic [1:0] o);
    @(negedge clk);
    op = o;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    logic [2:0] prev;
    int         moves;

    repeat (3) @(negedge clk);
    check(ov1 == 1'b0 && c1 == 3'b000, "R1 reset dut1", {ov1, c1}, 0);
    check(ov2 == 1'b0 && c2 == 5'b0, "R1 reset dut2", {ov2, c2}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(ov1 == 1'b0 && c1 == 3'b000, "R1 after release", {ov1, c1}, 0);

    // table walk on the three-share unit
    for (int k = 0; k < 8; k++) begin
      a1  = VEC[k][6:4];
      b1  = VEC[k][3:1];
      ent = $urandom;
      run_op(VEC[k][8:7]);
      check(ov1 == 1'b1, "R2 valid after strobe", ov1, 1);
      if (VEC[k][8:7] == 2'b00)
        check((^c1) == VEC[k][0], "R3 table AND", ^c1, VEC[k][0]);
      else begin
        check((^c1) == VEC[k][0], "R4 table NOT", ^c1, VEC[k][0]);
        check(c1 == (a1 ^ 3'b001), "R4 table NOT shares", c1, a1 ^ 3'b001);
      end
    end
    @(negedge clk);
    check(ov1 == 1'b0, "R2 valid drops", ov1, 0);

    // random AND / NOT on both share counts
    for (int k = 0; k < 60; k++) begin
      logic [1:0] o;
      a1 = $urandom; b1 = $urandom;
      a2 = $urandom; b2 = $urandom;
      ent = $urandom;
      o = (k % 3 == 2) ? 2'b01 : 2'b00;
      run_op(o);
      if (o == 2'b00) begin
        check((^c1) == ((^a1) & (^b1)), "R3 rand AND t1", ^c1, (^a1) & (^b1));
        check((^c2) == ((^a2) & (^b2)), "R3 rand AND t2", ^c2, (^a2) & (^b2));
      end else begin
        check(c1 == (a1 ^ 3'b001), "R4 rand NOT t1", c1, a1 ^ 3'b001);
        check(c2 == (a2 ^ 5'b00001), "R4 rand NOT t2", c2, a2 ^ 5'b00001);
      end
    end

    // LOAD then idle hold
    a1 = 3'b101;
    run_op(2'b11);
    check(c1 == 3'b101, "R8 load copy", c1, 3'b101);
    a1 = 3'b010;
    repeat (3) @(negedge clk);
    check(c1 == 3'b101 && ov1 == 1'b0, "R6 hold while idle", c1, 3'b101);

    // refresh chain with zero entropy, operands scrambled
    ent = '0;
    prev = c1;
    moves = 0;
    for (int k = 0; k < 8; k++) begin
      a1 = $urandom; b1 = $urandom;
      run_op(2'b10);
      check((^c1) == 1'b0, "R5 refresh keeps value", ^c1, 0);
      if (c1 != prev) moves++;
      prev = c1;
    end
    check(moves > 0, "R7 refresh pattern moves", moves, 1);

    a1 = 3'b100;
    run_op(2'b11);
    ent = $urandom;
    run_op(2'b10);
    check((^c1) == 1'b1, "R5 refresh keeps one", ^c1, 1);

    // mid-run reset
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(c1 == 3'b000 && ov1 == 1'b0, "R1 mid-run reset", c1, 0);

    finish_run();
  end
endmodule